// File: doc/BRIEF.md
# Three-Term Emulated FP32 Dot Product

This block forms an approximate single-precision dot product of two vectors when every single-precision element has already been split into a half-precision leading part and a half-precision remainder. The remainder was multiplied by a power of two, 2^sb, before storage so that it stays in the normal half-precision range. Only half-by-half multiplications are used. Each element pair yields three products: lead·lead, remainder_a·lead_b and lead_a·remainder_b. The remainder·remainder product is never formed. All sums are kept in single precision and rounded to nearest-even.

Two accumulation orders can be selected. In the term-separated order, each of the three product kinds goes into its own accumulator over the whole vector. At the end, the two correction sums are each divided by 2^sb, added to each other, and only then added to the main sum. In the merged order, each element pair adds its lead product and then its two descaled correction products into one accumulator.

Element pairs arrive over a valid/ready stream with first and last markers. One result per vector leaves over a second valid/ready stream. The input stream accepts a beat only while no result is being finished or held. After the last beat of a vector, `in_ready` stays low until `out_ready` takes the result. A result, once valid, holds still until it is taken. Inputs must be finite. Half-precision subnormal inputs are allowed.

Top module: `emu_dot3`

## Requirements
- R1: Per element pair the products formed are exactly a_hi·b_hi, a_lo·b_hi and a_hi·b_lo, each exact in single precision (half-precision subnormals included). a_lo·b_lo never influences the result.
- R2: With `mode_elem`=0, the result is main + (lo_a_sum/2^sb + lo_b_sum/2^sb). Each of the three sums is accumulated separately, and the two descaled correction sums are added together before the main sum.
- R3: With `mode_elem`=1, each pair is added to a single accumulator in this order: the lead product, then a_lo·b_hi/2^sb, then a_hi·b_lo/2^sb, with each addition rounded.
- R4: Every addition rounds to nearest with ties to even. For example, 2^24+1 gives 2^24, and 2^24+2 then +1 gives 2^24+4.
- R5: Division by 2^sb subtracts sb from the biased exponent. A value whose biased exponent is not larger than sb becomes zero of the same sign.
- R6: `mode_elem` and `corr_shift` are sampled on the beat carrying `in_first`. Changes on later beats of the same vector have no effect.
- R7: A beat with `in_first` starts all accumulators from +0. The accepted beat with `in_last` ends the vector and yields exactly one result.
- R8: `out_valid` rises two cycles after the clock edge that accepts the last beat. `in_ready` is low from that edge until the result is taken. While `out_valid` is high and `out_ready` is low, `out_data` is stable.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.
- R10: A valid result is never subnormal: a zero exponent field comes with a zero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_elem | input | 1 | 1 = merged order, 0 = term-separated order (sampled on first beat) |
| corr_shift | input | SB_W | Scale exponent sb of the remainders (sampled on first beat) |
| in_valid | input | 1 | Element pair present |
| in_ready | output | 1 | Block accepts an element pair |
| in_first | input | 1 | Beat is the first of a vector |
| in_last | input | 1 | Beat is the last of a vector |
| a_hi | input | 16 | Leading half of element a |
| a_lo | input | 16 | Scaled remainder half of element a |
| b_hi | input | 16 | Leading half of element b |
| b_lo | input | 16 | Scaled remainder half of element b |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Single-precision dot product |

## Verification
The hardest case to reach is a disagreement between the two accumulation orders. Random operands almost never show one, because both orders then produce the same exact value. The stimulus therefore builds vectors whose main sum sits at 2^24, where a correction of 1 is a rounding tie. Corrections of exactly 1, or a carefully placed odd main sum, separate merged from term-separated results and expose both tie directions. Flush to zero is reached by pairing the smallest normal half-precision remainder with a shift exponent just above its exponent. Sweeps then flip the mode and shift inputs in the middle of vectors to show that they are ignored.

// File: rtl/emu_fp_pkg.sv
package emu_fp_pkg;
  typedef logic [15:0] fp16_t;
  typedef logic [31:0] fp32_t;

  typedef enum logic [1:0] {ST_ACC, ST_FIN, ST_OUT} dot_state_e;

  // number of zeros above the highest set bit; 32 for an all-zero word
  function automatic logic [5:0] lead_zeros32(input logic [31:0] v);
    logic [5:0] n;
    n = 6'd32;
    for (int i = 0; i < 32; i++)
      if (v[i]) n = 6'(31 - i);
    return n;
  endfunction
endpackage

// File: rtl/emu_fp16_mul.sv
module emu_fp16_mul
  import emu_fp_pkg::*;
(
  input  fp16_t x,
  input  fp16_t y,
  output fp32_t prod
);
  logic [10:0] sig_x, sig_y;
  logic [5:0]  exp_x, exp_y, lz;
  logic [21:0] raw;
  logic [22:0] frac;
  logic [8:0]  exp_o;

  always_comb begin
    sig_x = {x[14:10] != 5'd0, x[9:0]};
    sig_y = {y[14:10] != 5'd0, y[9:0]};
    exp_x = (x[14:10] == 5'd0) ? 6'd1 : {1'b0, x[14:10]};
    exp_y = (y[14:10] == 5'd0) ? 6'd1 : {1'b0, y[14:10]};
    raw   = 22'(sig_x) * 22'(sig_y);
    lz    = lead_zeros32({raw, 10'b0});
    // shift the hidden one out, leaving the fraction left-aligned
    frac  = 23'({raw, 1'b0} << (lz + 6'd1));
    exp_o = 9'(exp_x) + 9'(exp_y) + 9'd98 - 9'(lz);
    if (raw == 22'd0) prod = {x[15] ^ y[15], 31'b0};
    else              prod = {x[15] ^ y[15], exp_o[7:0], frac};
  end
endmodule

// File: rtl/emu_fp32_scale.sv
module emu_fp32_scale
  import emu_fp_pkg::*;
#(
  parameter int SB_W = 7
) (
  input  fp32_t           x,
  input  logic [SB_W-1:0] sh,
  output fp32_t           y
);
  logic [8:0] e;
  always_comb begin
    e = {1'b0, x[30:23]};
    if (e == 9'd0)            y = x;
    else if (e <= 9'(sh))     y = {x[31], 31'b0};
    else                      y = {x[31], 8'(e - 9'(sh)), x[22:0]};
  end
endmodule

// File: rtl/emu_fp32_add.sv
module emu_fp32_add
  import emu_fp_pkg::*;
(
  input  fp32_t a,
  input  fp32_t b,
  output fp32_t s
);
  fp32_t              big, sml;
  logic [7:0]         d;
  logic [5:0]         dc, lz;
  logic [26:0]        xs, yext, ys, dif, norm;
  logic [53:0]        tmp;
  logic [27:0]        sum;
  logic [24:0]        rs;
  logic               rnd, zero_res;
  logic signed [9:0]  en;
  logic [22:0]        mant;

  always_comb begin
    big  = (b[30:0] > a[30:0]) ? b : a;
    sml  = (b[30:0] > a[30:0]) ? a : b;
    d    = big[30:23] - sml[30:23];
    dc   = (d > 8'd28) ? 6'd28 : d[5:0];
    xs   = {1'b1, big[22:0], 3'b0};
    yext = {1'b1, sml[22:0], 3'b0};
    tmp  = {yext, 27'b0} >> dc;
    ys   = {tmp[53:28], tmp[27] | (|tmp[26:0])};
    sum  = {1'b0, xs} + {1'b0, ys};
    dif  = xs - ys;
    lz   = 6'd0;
    zero_res = 1'b0;
    if (big[31] == sml[31]) begin
      if (sum[27]) begin
        norm = {sum[27:2], sum[1] | sum[0]};
        en   = $signed({2'b0, big[30:23]}) + 10'sd1;
      end else begin
        norm = sum[26:0];
        en   = $signed({2'b0, big[30:23]});
      end
    end else begin
      lz       = lead_zeros32({dif, 5'b0});
      norm     = dif << lz;
      en       = $signed({2'b0, big[30:23]}) - $signed({4'b0, lz});
      zero_res = (dif == 27'd0);
    end
    rnd  = norm[2] & (norm[3] | norm[1] | norm[0]);
    rs   = {1'b0, norm[26:3]} + 25'(rnd);
    if (rs[24]) begin
      en   = en + 10'sd1;
      mant = rs[23:1];
    end else begin
      mant = rs[22:0];
    end

    if (a[30:23] == 8'd0 && b[30:23] == 8'd0) s = {a[31] & b[31], 31'b0};
    else if (a[30:23] == 8'd0)                s = b;
    else if (b[30:23] == 8'd0)                s = a;
    else if (zero_res)                        s = 32'd0;
    else if (en <= 10'sd0)                    s = {big[31], 31'b0};
    else if (en >= 10'sd255)                  s = {big[31], 8'hFF, 23'b0};
    else                                      s = {big[31], en[7:0], mant};
  end
endmodule

// File: rtl/emu_dot3.sv
module emu_dot3
  import emu_fp_pkg::*;
#(
  parameter int SB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_elem,
  input  logic [SB_W-1:0] corr_shift,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_first,
  input  logic            in_last,
  input  logic [15:0]     a_hi,
  input  logic [15:0]     a_lo,
  input  logic [15:0]     b_hi,
  input  logic [15:0]     b_lo,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_data
);
  localparam int NTERM = 3;
  localparam int NCORR = NTERM - 1;

  dot_state_e             state;
  logic [NTERM-1:0][31:0] acc, base, prod, sums, add_a, add_b;
  logic [NTERM-1:0][15:0] mul_x, mul_y;
  logic [NCORR-1:0][31:0] sc_in, sc_out;
  logic                   mode_q, elem_cur, fin, take;
  logic [SB_W-1:0]        sh_q, sh_cur;

  assign in_ready  = (state == ST_ACC);
  assign out_valid = (state == ST_OUT);
  assign fin       = (state == ST_FIN);
  assign take      = in_valid & in_ready;
  assign elem_cur  = in_first ? mode_elem  : mode_q;
  assign sh_cur    = in_first ? corr_shift : sh_q;

  // term 0: lead*lead, term 1: rem_a*lead_b, term 2: lead_a*rem_b
  assign mul_x = {a_hi, a_lo, a_hi};
  assign mul_y = {b_lo, b_hi, b_hi};

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign base[t] = in_first ? 32'd0 : acc[t];
    emu_fp16_mul u_mul (.x(mul_x[t]), .y(mul_y[t]), .prod(prod[t]));
    emu_fp32_add u_add (.a(add_a[t]), .b(add_b[t]), .s(sums[t]));
  end

  for (genvar c = 0; c < NCORR; c++) begin : g_scale
    assign sc_in[c] = fin ? acc[c+1] : prod[c+1];
    emu_fp32_scale #(.SB_W(SB_W)) u_scale (
      .x(sc_in[c]), .sh(fin ? sh_q : sh_cur), .y(sc_out[c]));
  end

  // adder routing: accumulate (separate or chained) or final combine
  always_comb begin
    add_a[0] = base[0];
    add_b[0] = prod[0];
    if (fin) begin
      add_a[1] = sc_out[0];  add_b[1] = sc_out[1];
      add_a[2] = acc[0];     add_b[2] = sums[1];
    end else if (elem_cur) begin
      add_a[1] = sums[0];    add_b[1] = sc_out[0];
      add_a[2] = sums[1];    add_b[2] = sc_out[1];
    end else begin
      add_a[1] = base[1];    add_b[1] = prod[1];
      add_a[2] = base[2];    add_b[2] = prod[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ACC;
      acc      <= '0;
      mode_q   <= 1'b0;
      sh_q     <= '0;
      out_data <= '0;
    end else begin
      unique case (state)
        ST_ACC: if (take) begin
          mode_q <= elem_cur;
          sh_q   <= sh_cur;
          if (elem_cur) acc <= {32'd0, 32'd0, sums[2]};
          else          acc <= sums;
          if (in_last) state <= ST_FIN;
        end
        ST_FIN: begin
          out_data <= mode_q ? acc[0] : sums[2];
          state    <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_ACC;
        default: state <= ST_ACC;
      endcase
    end
  end
endmodule

// File: rtl/emu_dot3_chk.sv
module emu_dot3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  a_r8_last_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  a_r8_result_two_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> ##1 out_valid);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_no_input_while_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r7_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  a_r10_never_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[30:23] != 8'd0 || out_data[22:0] == 23'd0));
endmodule

bind emu_dot3 emu_dot3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/emu_dot3_tb.sv
`timescale 1ns/1ps
module emu_dot3_tb;
  localparam int SB_W = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode_elem = 1'b0;
  logic [SB_W-1:0] corr_shift = '0;
  logic            in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [15:0]     a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic            out_ready = 1'b0;
  logic            in_ready, out_valid;
  logic [31:0]     out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned seed = 32'd12345;

  always #2.5 clk = ~clk;

  emu_dot3 #(.SB_W(SB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_elem(mode_elem), .corr_shift(corr_shift),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_last(in_last), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] r2h(input real r);
    logic [63:0] b;
    if (r == 0.0) return 16'h0000;
    b = $realtobits(r);
    return {b[63], 5'(b[62:52] - 11'd1008), b[51:42]};
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] b;
    if (r == 0.0) return 32'h0;
    b = $realtobits(r);
    return {b[63], 8'(b[62:52] - 11'd896), b[51:29]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] ah, al, bh, bl, input logic f, l,
                      input logic m, input logic [SB_W-1:0] sh);
    @(negedge clk);
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl;
    in_first = f; in_last = l; in_valid = 1'b1;
    mode_elem = m; corr_shift = sh;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // called right after the edge accepting the last beat
  task automatic take(input string req, input logic [31:0] exp, input int hold);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    check("R8 finishing cycle", {30'd0, out_valid, in_ready}, 32'd0);
    @(negedge clk);
    check("R8 result after two cycles", {31'd0, out_valid}, 32'd1);
    check(req, out_data, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 stall holds", {30'd0, out_valid, in_ready}, 32'd2);
      check("R8 stall data", out_data, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R7 one result only", {31'd0, out_valid}, 32'd0);
  endtask

  function automatic int next_int();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 16) % 31) - 15;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    real ahr[5], alr[5], bhr[5], blr[5];
    real shh, slh, shl, sc, expr;
    int  sbl[3];
    sbl[0] = 0; sbl[1] = 2; sbl[2] = 4;

    repeat (3) @(negedge clk);
    check("R9 reset in_ready/out_valid", {30'd0, in_ready, out_valid}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {30'd0, in_ready, out_valid}, 32'd2);

    // sweep: both orders, several shifts, lengths 1..5, controls flipped mid-vector (R2 R3 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int si = 0; si < 3; si++)
        for (int len = 1; len <= 5; len++) begin
          shh = 0.0; slh = 0.0; shl = 0.0;
          sc = 2.0 ** sbl[si];
          for (int i = 0; i < len; i++) begin
            ahr[i] = real'(next_int());
            bhr[i] = real'(next_int());
            alr[i] = real'(next_int()) * 0.125;
            blr[i] = real'(next_int()) * 0.125;
            shh += ahr[i] * bhr[i];
            slh += alr[i] * bhr[i];
            shl += ahr[i] * blr[i];
          end
          expr = shh + (slh / sc + shl / sc);
          for (int i = 0; i < len; i++)
            send(r2h(ahr[i]), r2h(alr[i]), r2h(bhr[i]), r2h(blr[i]),
                 i == 0, i == len - 1,
                 (i == 0) ? m[0] : ~m[0],
                 (i == 0) ? SB_W'(sbl[si]) : SB_W'(sbl[si] + 1));
          take(m == 0 ? "R2 R6 term-separated sweep" : "R3 R6 merged sweep",
               r2f(expr), (len == 3) ? 3 : 0);
        end

    // tie at 2^24: merged drops both corrections, term-separated keeps their sum
    send(r2h(4096.0), r2h(2.0 ** -12), r2h(4096.0), r2h(2.0 ** -12), 1'b1, 1'b1, 1'b1, '0);
    take("R3 R4 merged tie to even", 32'h4B80_0000, 2);
    send(r2h(4096.0), r2h(2.0 ** -12), r2h(4096.0), r2h(2.0 ** -12), 1'b1, 1'b1, 1'b0, '0);
    take("R2 corrections combined first", 32'h4B80_0001, 0);

    // odd lsb tie rounds up
    send(r2h(4096.0), 16'h0, r2h(4096.0), 16'h0, 1'b1, 1'b0, 1'b1, '0);
    send(r2h(1.0), 16'h0, r2h(2.0), 16'h0, 1'b0, 1'b0, 1'b1, '0);
    send(16'h0, r2h(1.0), r2h(1.0), 16'h0, 1'b0, 1'b1, 1'b1, '0);
    take("R4 tie rounds up to even", 32'h4B80_0002, 0);

    // remainder*remainder never used
    send(16'h0, r2h(3.0), 16'h0, r2h(5.0), 1'b1, 1'b1, 1'b0, '0);
    take("R1 lo*lo dropped term", 32'h0, 0);
    send(16'h0, r2h(3.0), 16'h0, r2h(5.0), 1'b1, 1'b1, 1'b1, '0);
    take("R1 lo*lo dropped merged", 32'h0, 0);

    // exact products incl. subnormal and full-width significands
    send(16'h0001, 16'h0, 16'h0001, 16'h0, 1'b1, 1'b1, 1'b0, '0);
    take("R1 subnormal product exact", r2f(2.0 ** -48), 0);
    send(r2h(2047.0 / 1024.0), 16'h0, r2h(2047.0 / 1024.0), 16'h0, 1'b1, 1'b1, 1'b0, '0);
    take("R1 full significand product exact", r2f((2047.0 * 2047.0) / 1048576.0), 0);

    // descale boundary and flush
    send(16'h0, 16'h0400, r2h(1.0), 16'h0, 1'b1, 1'b1, 1'b0, SB_W'(112));
    take("R5 smallest normal kept", 32'h0080_0000, 0);
    send(16'h0, 16'h0400, r2h(1.0), 16'h0, 1'b1, 1'b1, 1'b0, SB_W'(113));
    take("R5 R10 flush to zero term", 32'h0, 0);
    send(16'h0, 16'h0400, r2h(1.0), 16'h0, 1'b1, 1'b1, 1'b1, SB_W'(113));
    take("R5 R10 flush to zero merged", 32'h0, 0);
    send(16'h0, 16'h8400, r2h(1.0), 16'h0, 1'b1, 1'b1, 1'b0, SB_W'(112));
    take("R5 negative descale", 32'h8080_0000, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule